// File: doc/BRIEF.md
# Speculation-Consistent Return Address Stack

This block predicts return targets for a speculative front end while keeping an exact record of which stacked return addresses are architecturally committed. Decoded calls push their fall-through address and decoded returns pop the top entry as the predicted target. The popped value also travels back to the pipeline, to be parked beside the return in the reorder buffer. When a misprediction squashes younger work, the pipeline replays the squashed calls and returns youngest first as undo operations. Each undo reverses exactly what its decode did, so the stack comes back to its pre-speculation contents.

Commits arrive on a separate plain control port. A committed call moves the committed boundary up by one entry. A committed return moves it down by one and compares the value saved with that return against the architectural return address, flagging a control-flow integrity violation on a mismatch. The committed boundary is exposed as a physical index, `commit_ptr`, into the circular entry file.

The stack never overwrites on overflow. A push into a full stack first spills the four oldest committed entries to backing memory through a request/acknowledge pair and stalls until memory acknowledges. A pop from an empty stack with entries still held in memory first refills a group of four and stalls the same way. Operations enter through a valid/ready channel, and predictions leave through another valid/ready channel. An operation is accepted only when `op_valid` and `op_ready` are both high at a clock edge. `op_ready` stays low while a prediction is waiting for `pred_ready`, while a spill or refill is pending, or while the offered operation itself needs one. A prediction stays valid with a stable target until `pred_ready` is seen high.

Top module: `spec_ret_stack`

## Requirements
- R1: After reset, `pred_valid`, `spill_req`, `fill_req` and `cfi_violation` are low, `op_ready` is high for an offered call, and `commit_ptr` equals DEPTH-1 (15 by default).
- R2: Operation codes are 0 = decoded call, 1 = decoded return, 2 = undo of a call, 3 = undo of a return. A decoded call pushes `op_addr`. A decoded return accepted at edge N raises `pred_valid` after edge N, with `pred_target` equal to the most recently pushed live entry, in last-in first-out order.
- R3: While `pred_valid` is high and `pred_ready` is low, `pred_valid` stays high, `pred_target` holds its value and `op_ready` is low.
- R4: A commit with `cm_is_ret` low advances `commit_ptr` by one, and a commit with `cm_is_ret` high moves it back by one, both visible after that edge. Decoded and undo operations never change `commit_ptr`.
- R5: An undo of a call removes the top entry, and an undo of a return pushes `op_addr` (its saved value) back. Replaying a squashed window youngest first restores the predictions later returns receive.
- R6: An offered push into a stack holding 16 entries, with at least four committed entries on chip that no in-flight return has popped, raises `spill_req`. `spill_data` then carries the four oldest entries, oldest in bits [AW-1:0]. Both stay stable and the push is held until `spill_done`, after which the push completes and `commit_ptr` keeps its value.
- R7: If fewer than four such committed entries exist, a push into a full stack stalls with `op_ready` low and `spill_req` low until enough calls commit.
- R8: An offered decoded return with no entries on chip while memory holds entries raises `fill_req`. On `fill_done` the four words of `fill_data` (oldest in bits [AW-1:0]) are placed beneath the stack, and the held return then pops the youngest of them. `commit_ptr` keeps its value.
- R9: A decoded return with no entries on chip or in memory predicts 0 and leaves the stack unchanged.
- R10: A committed return whose `cm_saved` differs from `cm_arch` raises `cfi_violation` for exactly the one cycle after that edge. A matching commit leaves it low.
- R11: `spill_req` and `fill_req` are never high together, and no operation is accepted while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation accepted at this edge when valid |
| op_code | input | 2 | 0 call, 1 return, 2 undo call, 3 undo return |
| op_addr | input | AW | Return address for a call, saved value for an undo return |
| pred_valid | output | 1 | Predicted target available |
| pred_ready | input | 1 | Consumer takes the prediction |
| pred_target | output | AW | Predicted target, also the value to save with the return |
| cm_valid | input | 1 | A call or return commits this cycle |
| cm_is_ret | input | 1 | Committing instruction is a return |
| cm_saved | input | AW | Saved value of the committing return |
| cm_arch | input | AW | Architectural return address of the committing return |
| cfi_violation | output | 1 | One-cycle flag for a return mismatch |
| commit_ptr | output | log2(DEPTH) | Physical index of the last committed entry |
| spill_req | output | 1 | Request to write one group to memory |
| spill_data | output | GRP*AW | Group being spilled, oldest lowest |
| spill_done | input | 1 | Memory accepted the spill |
| fill_req | output | 1 | Request to read one group from memory |
| fill_data | input | GRP*AW | Group returned, oldest lowest |
| fill_done | input | 1 | Fill data valid this cycle |

## Verification
A wrong stack pointer or a lost undo shows at the ports on the next decoded return, which delivers a target the bench's own last-in first-out model does not expect, one cycle after acceptance. Wrong committed-depth or low-water accounting shows as a spill raised too early or never raised, or as a stale `commit_ptr` one cycle after a commit. A wrong spill group or wrong refill placement surfaces later, when the refilled entries are popped and their order or values differ from the model. Back-pressure faults show within the held cycles as a dropped or changing prediction.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    OP_CALL      = 2'd0,
    OP_RET       = 2'd1,
    OP_UNDO_CALL = 2'd2,
    OP_UNDO_RET  = 2'd3
  } srs_op_e;
endpackage

// File: rtl/srs_entry_file.sv
// Circular storage: one single-entry write port (push), one group write
// port (refill), one single-entry read port (top) and one group read port
// (spill source).
module srs_entry_file #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int GRP   = 4
) (
  input  logic                       clk,
  input  logic                       push_we,
  input  logic [$clog2(DEPTH)-1:0]   push_idx,
  input  logic [AW-1:0]              push_data,
  input  logic                       grp_we,
  input  logic [$clog2(DEPTH)-1:0]   grp_base,
  input  logic [GRP*AW-1:0]          grp_data,
  input  logic [$clog2(DEPTH)-1:0]   top_idx,
  output logic [AW-1:0]              top_data,
  input  logic [$clog2(DEPTH)-1:0]   spill_base,
  output logic [GRP*AW-1:0]          spill_data
);
  localparam int IW = $clog2(DEPTH);

  logic [AW-1:0] slot_q [DEPTH];

  always_ff @(posedge clk) begin
    if (push_we) slot_q[push_idx] <= push_data;
    if (grp_we) begin
      for (int k = 0; k < GRP; k++) begin
        slot_q[grp_base + IW'(k)] <= grp_data[k*AW +: AW];
      end
    end
  end

  assign top_data = slot_q[top_idx];

  for (genvar g = 0; g < GRP; g++) begin : g_spill_rd
    assign spill_data[g*AW +: AW] = slot_q[spill_base + IW'(g)];
  end
endmodule

// File: rtl/srs_mem_link.sv
// Spill/refill request registers and the count of entries parked in memory.
module srs_mem_link #(
  parameter int GRP = 4,
  parameter int MW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_spill,
  input  logic          want_fill,
  input  logic          spill_done,
  input  logic          fill_done,
  output logic          spill_req,
  output logic          fill_req,
  output logic          spill_fire,
  output logic          fill_fire,
  output logic [MW-1:0] mem_depth
);
  assign spill_fire = spill_req && spill_done;
  assign fill_fire  = fill_req && fill_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spill_req <= 1'b0;
      fill_req  <= 1'b0;
      mem_depth <= '0;
    end else begin
      if (spill_fire) begin
        spill_req <= 1'b0;
        mem_depth <= mem_depth + MW'(GRP);
      end else if (fill_fire) begin
        fill_req  <= 1'b0;
        mem_depth <= mem_depth - MW'(GRP);
      end else if (!spill_req && !fill_req) begin
        if (want_spill)     spill_req <= 1'b1;
        else if (want_fill) fill_req  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/srs_commit_track.sv
// Committed logical depth (on chip plus memory) and the return check.
module srs_commit_track #(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cm_valid,
  input  logic          cm_is_ret,
  input  logic [AW-1:0] cm_saved,
  input  logic [AW-1:0] cm_arch,
  output logic [MW-1:0] cdepth,
  output logic          cfi_violation
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cdepth        <= '0;
      cfi_violation <= 1'b0;
    end else begin
      cfi_violation <= cm_valid && cm_is_ret && (cm_saved != cm_arch);
      if (cm_valid) begin
        if (cm_is_ret) cdepth <= cdepth - MW'(1);
        else           cdepth <= cdepth + MW'(1);
      end
    end
  end
endmodule

// File: rtl/spec_ret_stack.sv
module spec_ret_stack
  import srs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int GRP   = 4,
  parameter int MW    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_valid,
  output logic                      op_ready,
  input  logic [1:0]                op_code,
  input  logic [AW-1:0]             op_addr,
  output logic                      pred_valid,
  input  logic                      pred_ready,
  output logic [AW-1:0]             pred_target,
  input  logic                      cm_valid,
  input  logic                      cm_is_ret,
  input  logic [AW-1:0]             cm_saved,
  input  logic [AW-1:0]             cm_arch,
  output logic                      cfi_violation,
  output logic [$clog2(DEPTH)-1:0]  commit_ptr,
  output logic                      spill_req,
  output logic [GRP*AW-1:0]         spill_data,
  input  logic                      spill_done,
  output logic                      fill_req,
  input  logic [GRP*AW-1:0]         fill_data,
  input  logic                      fill_done
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  srs_op_e code;
  assign code = srs_op_e'(op_code);

  // occupancy, bottom index, low-water mark of unpopped entries
  logic [CW-1:0] cnt, lw, lw_n;
  logic [IW-1:0] bot;
  logic [MW-1:0] spec_ret, spec_ret_n;
  logic [MW-1:0] cdepth, mem_depth, onchip_c;

  logic is_push, dec_ret, undo_call, undo_ret;
  logic st_full, st_empty, mem_has, pred_free, blocked, acc, ok_spill;
  logic want_spill, want_fill, spill_fire, fill_fire;
  logic [IW-1:0] wr_idx, top_idx;
  logic [AW-1:0] top_data;

  assign is_push   = (code == OP_CALL) || (code == OP_UNDO_RET);
  assign dec_ret   = (code == OP_RET);
  assign undo_call = (code == OP_UNDO_CALL);
  assign undo_ret  = (code == OP_UNDO_RET);

  assign st_full   = (cnt == CW'(DEPTH));
  assign st_empty  = (cnt == '0);
  assign mem_has   = (mem_depth != '0);
  assign pred_free = !pred_valid || pred_ready;

  // committed entries currently attributed to the on-chip part
  assign onchip_c = cdepth - mem_depth;
  assign ok_spill = (onchip_c >= MW'(GRP)) && (lw >= CW'(GRP));

  assign blocked  = spill_req || fill_req ||
                    (is_push && st_full) ||
                    (dec_ret && st_empty && mem_has);
  assign op_ready = pred_free && !blocked;
  assign acc      = op_valid && op_ready;

  assign want_spill = op_valid && is_push && st_full && ok_spill;
  assign want_fill  = op_valid && dec_ret && st_empty && mem_has;

  assign wr_idx     = bot + cnt[IW-1:0];
  assign top_idx    = wr_idx - IW'(1);
  assign commit_ptr = bot + onchip_c[IW-1:0] - IW'(1);

  srs_entry_file #(.AW(AW), .DEPTH(DEPTH), .GRP(GRP)) u_file (
    .clk        (clk),
    .push_we    (acc && is_push),
    .push_idx   (wr_idx),
    .push_data  (op_addr),
    .grp_we     (fill_fire),
    .grp_base   (bot - IW'(GRP)),
    .grp_data   (fill_data),
    .top_idx    (top_idx),
    .top_data   (top_data),
    .spill_base (bot),
    .spill_data (spill_data)
  );

  srs_mem_link #(.GRP(GRP), .MW(MW)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_spill (want_spill),
    .want_fill  (want_fill),
    .spill_done (spill_done),
    .fill_done  (fill_done),
    .spill_req  (spill_req),
    .fill_req   (fill_req),
    .spill_fire (spill_fire),
    .fill_fire  (fill_fire),
    .mem_depth  (mem_depth)
  );

  srs_commit_track #(.AW(AW), .MW(MW)) u_commit (
    .clk           (clk),
    .rst_n         (rst_n),
    .cm_valid      (cm_valid),
    .cm_is_ret     (cm_is_ret),
    .cm_saved      (cm_saved),
    .cm_arch       (cm_arch),
    .cdepth        (cdepth),
    .cfi_violation (cfi_violation)
  );

  // in-flight decoded returns; while any exist, committed entries they
  // popped must not leave the chip
  always_comb begin
    spec_ret_n = spec_ret;
    if (acc && dec_ret && !st_empty) spec_ret_n = spec_ret_n + MW'(1);
    if (acc && undo_ret)             spec_ret_n = spec_ret_n - MW'(1);
    if (cm_valid && cm_is_ret)       spec_ret_n = spec_ret_n - MW'(1);
  end

  always_comb begin
    lw_n = lw;
    if (spill_fire) begin
      lw_n = (lw >= CW'(GRP)) ? lw - CW'(GRP) : '0;
    end else if (fill_fire) begin
      lw_n = (lw > CW'(DEPTH - GRP)) ? CW'(DEPTH) : lw + CW'(GRP);
    end
    if (acc && dec_ret && !st_empty && ((cnt - CW'(1)) < lw_n)) lw_n = cnt - CW'(1);
    if (spec_ret_n == '0) lw_n = CW'(DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      bot         <= '0;
      lw          <= CW'(DEPTH);
      spec_ret    <= '0;
      pred_valid  <= 1'b0;
      pred_target <= '0;
    end else begin
      lw       <= lw_n;
      spec_ret <= spec_ret_n;
      if (spill_fire) begin
        cnt <= cnt - CW'(GRP);
        bot <= bot + IW'(GRP);
      end else if (fill_fire) begin
        cnt <= cnt + CW'(GRP);
        bot <= bot - IW'(GRP);
      end else if (acc) begin
        if (is_push)                                cnt <= cnt + CW'(1);
        else if (undo_call || (dec_ret && !st_empty)) cnt <= cnt - CW'(1);
      end
      if (pred_valid && pred_ready) pred_valid <= 1'b0;
      if (acc && dec_ret) begin
        pred_valid  <= 1'b1;
        pred_target <= st_empty ? '0 : top_data;
      end
    end
  end
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int GRP   = 4,
  parameter int MW    = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid,
  input logic                    op_ready,
  input logic [1:0]              op_code,
  input logic                    pred_valid,
  input logic                    pred_ready,
  input logic [AW-1:0]           pred_target,
  input logic                    cm_valid,
  input logic                    cm_is_ret,
  input logic [AW-1:0]           cm_saved,
  input logic [AW-1:0]           cm_arch,
  input logic                    cfi_violation,
  input logic                    spill_req,
  input logic [GRP*AW-1:0]       spill_data,
  input logic                    spill_done,
  input logic                    fill_req,
  input logic                    fill_done,
  input logic [MW-1:0]           cdepth,
  input logic [$clog2(DEPTH+1)-1:0] cnt
);
  p_pred_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !pred_ready |=> pred_valid && $stable(pred_target));

  p_pred_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !pred_ready |-> !op_ready);

  p_cdepth_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && cm_is_ret |-> cdepth != '0);

  p_undo_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && op_code == 2'd2 |-> cnt != '0);

  p_spill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req && !spill_done |=> spill_req && $stable(spill_data));

  p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_done |=> fill_req);

  p_cfi_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && cm_is_ret && (cm_saved != cm_arch) |=> cfi_violation);

  p_cfi_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_valid && cm_is_ret && (cm_saved != cm_arch)) |=> !cfi_violation);

  p_req_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spill_req, fill_req}));

  p_req_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req || fill_req |-> !op_ready);
endmodule

bind spec_ret_stack srs_checker #(.AW(AW), .DEPTH(DEPTH), .GRP(GRP), .MW(MW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .op_code       (op_code),
  .pred_valid    (pred_valid),
  .pred_ready    (pred_ready),
  .pred_target   (pred_target),
  .cm_valid      (cm_valid),
  .cm_is_ret     (cm_is_ret),
  .cm_saved      (cm_saved),
  .cm_arch       (cm_arch),
  .cfi_violation (cfi_violation),
  .spill_req     (spill_req),
  .spill_data    (spill_data),
  .spill_done    (spill_done),
  .fill_req      (fill_req),
  .fill_done     (fill_done),
  .cdepth        (cdepth),
  .cnt           (cnt)
);

// File: tb/tb_spec_ret_stack.sv
module tb_spec_ret_stack;
  localparam int CLK_P = 10;
  localparam int QT    = CLK_P / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [1:0]    op_code = 2'd0;
  logic [31:0]   op_addr = '0;
  logic          pred_valid;
  logic          pred_ready = 1'b1;
  logic [31:0]   pred_target;
  logic          cm_valid = 1'b0;
  logic          cm_is_ret = 1'b0;
  logic [31:0]   cm_saved = '0;
  logic [31:0]   cm_arch = '0;
  logic          cfi_violation;
  logic [3:0]    commit_ptr;
  logic          spill_req;
  logic [127:0]  spill_data;
  logic          spill_done = 1'b0;
  logic          fill_req;
  logic [127:0]  fill_data = '0;
  logic          fill_done = 1'b0;

  spec_ret_stack dut (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code), .op_addr(op_addr),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_target(pred_target),
    .cm_valid(cm_valid), .cm_is_ret(cm_is_ret), .cm_saved(cm_saved), .cm_arch(cm_arch),
    .cfi_violation(cfi_violation), .commit_ptr(commit_ptr),
    .spill_req(spill_req), .spill_data(spill_data), .spill_done(spill_done),
    .fill_req(fill_req), .fill_data(fill_data), .fill_done(fill_done)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R2";
  logic [31:0]  mdl[$];
  logic [31:0]  exp_q[$];
  logic [127:0] mq[$];
  logic [127:0] last_spill = '0;
  int spill_seen = 0;
  int fill_seen  = 0;
  bit op_done = 1'b0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    @(negedge clk);
    #(QT);
  endtask

  // driver: offers one operation, updates the reference stack on acceptance
  task automatic op(input logic [1:0] code, input logic [31:0] a);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = code;
    op_addr  = a;
    forever begin
      #(QT);
      if (op_ready === 1'b1) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 op_valid = 1'b0;
    case (code)
      2'd0: mdl.push_back(a);
      2'd1: exp_q.push_back(mdl.size() != 0 ? mdl.pop_back() : 32'h0);
      2'd2: void'(mdl.pop_back());
      default: mdl.push_back(a);
    endcase
  endtask

  task automatic commit(input bit is_ret, input logic [31:0] saved, input logic [31:0] arch);
    @(negedge clk);
    cm_valid  = 1'b1;
    cm_is_ret = is_ret;
    cm_saved  = saved;
    cm_arch   = arch;
    @(posedge clk);
    #1 cm_valid = 1'b0;
  endtask

  // monitor: compares every delivered prediction against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(QT);
      if (rst_n) begin
        if (spill_req && fill_req) chk("R11 spill and fill together", 1, 0);
        if (pred_valid && pred_ready) begin
          if (exp_q.size() == 0) chk({cur_tag, " unexpected prediction"}, pred_target, 128'hx);
          else chk({cur_tag, " predicted target"}, pred_target, exp_q.pop_front());
        end
      end
    end
  end

  // backing memory responder
  initial begin
    forever begin
      @(negedge clk);
      #(QT);
      if (spill_req) begin
        last_spill = spill_data;
        mq.push_back(spill_data);
        spill_seen++;
        @(negedge clk); spill_done = 1'b1;
        @(negedge clk); spill_done = 1'b0;
      end else if (fill_req) begin
        fill_data = (mq.size() != 0) ? mq.pop_back() : '0;
        fill_seen++;
        @(negedge clk); fill_done = 1'b1;
        @(negedge clk); fill_done = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [31:0] fa(input int i);
    return 32'h1000_0000 + 32'(i * 4);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sample();
    // R1
    chk("R1 pred_valid", pred_valid, 0);
    chk("R1 spill_req", spill_req, 0);
    chk("R1 fill_req", fill_req, 0);
    chk("R1 cfi_violation", cfi_violation, 0);
    chk("R1 op_ready", op_ready, 1);
    chk("R1 commit_ptr", commit_ptr, 15);

    // R2 and R4: LIFO with commits in order
    cur_tag = "R2";
    op(2'd0, 32'hA1); op(2'd0, 32'hA2); op(2'd0, 32'hA3);
    commit(0, 0, 0); sample(); chk("R4 ptr after call commit", commit_ptr, 0);
    commit(0, 0, 0); commit(0, 0, 0); sample(); chk("R4 ptr after three commits", commit_ptr, 2);
    op(2'd1, 0); op(2'd1, 0); op(2'd1, 0);
    sample(); chk("R4 decode leaves ptr", commit_ptr, 2);
    commit(1, 32'hA3, 32'hA3); sample(); chk("R4 ptr after return commit", commit_ptr, 1);
    commit(1, 32'hA2, 32'hA2); commit(1, 32'hA1, 32'hA1);
    sample(); chk("R4 ptr back to reset value", commit_ptr, 15);

    // R3: held prediction
    cur_tag = "R3";
    @(negedge clk); pred_ready = 1'b0;
    op(2'd0, 32'hB0);
    op(2'd1, 0);
    repeat (3) sample();
    chk("R3 pred_valid held", pred_valid, 1);
    chk("R3 pred_target held", pred_target, 32'hB0);
    chk("R3 op_ready low", op_ready, 0);
    @(negedge clk); pred_ready = 1'b1;
    sample();
    commit(0, 0, 0); commit(1, 32'hB0, 32'hB0);

    // R10: return check
    cur_tag = "R10";
    op(2'd0, 32'hC1); op(2'd0, 32'hC2);
    commit(0, 0, 0); commit(0, 0, 0);
    op(2'd1, 0);
    commit(1, 32'hC2, 32'hC2); sample(); chk("R10 match stays quiet", cfi_violation, 0);
    op(2'd1, 0);
    commit(1, 32'hC1, 32'hBAD); sample(); chk("R10 mismatch flagged", cfi_violation, 1);
    sample(); chk("R10 flag lasts one cycle", cfi_violation, 0);
    chk("R4 ptr after cfi sequence", commit_ptr, 15);

    // R5: squash replay
    cur_tag = "R5";
    op(2'd0, 32'hD1); op(2'd0, 32'hD2);
    op(2'd1, 0);            // predicts D2
    op(2'd0, 32'hE0);
    op(2'd2, 0);            // undo call E0
    op(2'd3, 32'hD2);       // undo return, push D2 back
    op(2'd1, 0);            // D2 again
    op(2'd1, 0);            // D1
    sample(); chk("R5 undo leaves ptr", commit_ptr, 15);
    commit(0, 0, 0); commit(0, 0, 0);
    commit(1, 32'hD2, 32'hD2); commit(1, 32'hD1, 32'hD1);

    // R6 and R7: spill
    cur_tag = "R6";
    for (int i = 0; i < 16; i++) op(2'd0, fa(i));
    commit(0, 0, 0); commit(0, 0, 0); commit(0, 0, 0);
    sample(); chk("R7 ptr with three committed", commit_ptr, 2);
    fork
      begin op(2'd0, fa(16)); op_done = 1'b1; end
    join_none
    repeat (4) sample();
    chk("R7 push stalls", op_ready, 0);
    chk("R7 no spill yet", spill_req, 0);
    chk("R7 no spill seen", spill_seen, 0);
    commit(0, 0, 0);
    wait (op_done);
    sample();
    chk("R6 one spill", spill_seen, 1);
    chk("R6 spill group", last_spill, {fa(3), fa(2), fa(1), fa(0)});
    chk("R6 ptr kept", commit_ptr, 3);

    // R8 and R9: drain, refill, empty
    cur_tag = "R8";
    for (int i = 0; i < 13; i++) op(2'd1, 0);
    op(2'd1, 0);            // needs refill, predicts F3
    sample();
    chk("R8 one fill", fill_seen, 1);
    chk("R8 ptr kept", commit_ptr, 3);
    op(2'd1, 0); op(2'd1, 0); op(2'd1, 0);
    cur_tag = "R9";
    op(2'd1, 0);            // fully empty, predicts 0
    op(2'd0, 32'hF00D);
    op(2'd1, 0);
    repeat (3) sample();
    chk("R9 fill count unchanged", fill_seen, 1);
    chk("R2 all predictions delivered", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule